// File: doc/BRIEF.md
# SPI Register Access Engine

This block is an SPI master for a contactless-reader front-end chip. A host posts one request at a time: a register write, a register read, a FIFO burst write, a FIFO burst read, or a bulk write of the whole register set. The engine turns each request into one or two chip-select frames of 8-bit words. Mode is clock idle low with MISO captured on the rising edge, MSB first. The SCLK half-period is a parameter, `HALF_DIV` system clocks.

Every address byte carries the 6-bit register number in bits 6..1. Bit 0 is zero. Bit 7 flags a read and is set only on the first byte of a read frame. Payload bytes for writes come in on a valid/ready stream. A transfer takes place in any cycle where `wr_valid` and `wr_ready` are both high. The engine raises `wr_ready` only while it waits for a payload byte. If the source holds `wr_valid` low, the frame pauses: chip select stays low and SCLK stays low. Read data leaves on a valid-only stream, one cycle per byte. This stream has no back-pressure, so the consumer must take each byte in its `rd_valid` cycle. `done` pulses once per request. For reads it pulses in the same cycle as the last data byte.

Top module: `spi_reg_engine`

## Requirements
- R1: Opcodes on `req_op`: 0 register write, 1 register read, 2 FIFO write, 3 FIFO read, 4 register-set write. An address byte is {read flag, reg[5:0], 0}. Examples: reg 0x15 write gives 0x2A, and reg 0x3F read gives 0xFE.
- R2: A register write sends one 2-byte frame: the address byte with bit 7 clear, then `req_wdata`.
- R3: A register read sends the address byte with bit 7 set, then 0x00. The second byte received leaves on `rd_data`, with `rd_valid` and `done` high in the same cycle.
- R4: A FIFO write sends 0x04 (FIFO data register 0x02), then L payload bytes taken from the write stream. L is `req_len` clamped to 64, so a frame is at most 65 bytes. Any payload bytes beyond L are left untaken.
- R5: A FIFO read first runs a register-read frame of the level register 0x04 (0x88, 0x00) and takes N = min(received level, `req_len`). A second frame then sends 0x84, then 0x04 N-1 times, then 0x00. Received bytes 1..N leave in order on `rd_data`.
- R6: When N is 0, no second frame is sent. `done` pulses at the end of the level frame, and no `rd_valid` is raised.
- R7: A register-set write is one frame of 84 bytes. For each address from 0x11 to 0x3F, excluding multiples of 8, it sends the address byte and then one payload byte from the write stream, in rising address order.
- R8: SCLK is low whenever chip select is high. MOSI changes only while SCLK is low. Chip select stays low for a whole frame.
- R9: Chip select stays high for at least 2*HALF_DIV cycles between frames, including between the two frames of a FIFO read.
- R10: `req_ready` is high only when the engine is idle. No request is taken while a frame or gap is in progress.
- R11: Let A be the edge at which a request is accepted. With no write-stream stall, the last byte of a B-byte frame completes with `done` visible after edge A + B*(16*HALF_DIV+2).
- R12: While `wr_valid` is low at a payload slot, the frame waits with chip select low and SCLK low. `wr_ready` is high only inside a frame, between bytes.
- R13: Opcodes 5 to 7 are accepted and produce no frame. `done` pulses in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, takes the request |
| req_op | input | 3 | Operation code |
| req_addr | input | 6 | Register number |
| req_wdata | input | 8 | Data for a register write |
| req_len | input | 7 | Byte count for FIFO write, or maximum count for FIFO read |
| wr_valid | input | 1 | Payload byte offered |
| wr_ready | output | 1 | Engine takes a payload byte |
| wr_data | input | 8 | Payload byte |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request complete, one cycle |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the chip |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the chip |

## Verification
Each byte takes exactly 16*HALF_DIV+2 cycles, so a register access has a known `done` cycle. The bench counts falling clock edges from the acceptance edge and compares that count against R11's formula for 2-byte frames, and checks that R13's `done` arrives one edge after acceptance. Frame content is checked byte by byte as a slave model captures each word on SCLK rising edges. Read bytes are compared as `rd_valid` rises, with every output sampled on the falling system clock edge. The checks of queue emptiness are made one cycle after `done`, so that the last read byte is known to have been compared.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [2:0] OP_REG_WR  = 3'd0;
  localparam logic [2:0] OP_REG_RD  = 3'd1;
  localparam logic [2:0] OP_FIFO_WR = 3'd2;
  localparam logic [2:0] OP_FIFO_RD = 3'd3;
  localparam logic [2:0] OP_REG_SET = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP
  } eng_state_e;

  function automatic logic [7:0] addr_byte(input logic [5:0] reg_no, input logic rd);
    return {rd, reg_no, 1'b0};
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op <= OP_REG_SET;
  endfunction

  // number of registers in [first, last] that are not page registers
  function automatic int set_count(input int first, input int last);
    int n;
    n = 0;
    for (int a = first; a <= last; a++) begin
      if (a % 8 != 0) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    tx_q;
  logic [7:0]    rx_q;

  assign rx_byte = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        tx_q <= tx_byte;
        mosi <= tx_byte[7];
        sclk <= 1'b0;
        cnt  <= '0;
        bitn <= '0;
      end else if (busy) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx_q <= {rx_q[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              tx_q <= {tx_q[6:0], 1'b0};
              mosi <= tx_q[6];
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R8

endmodule

// File: rtl/spi_regset_walk.sv
module spi_regset_walk #(
  parameter logic [5:0] FIRST = 6'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  output logic [5:0] addr
);
  function automatic logic [5:0] skip_page(input logic [5:0] a);
    return (a[2:0] == 3'd0) ? a + 6'd1 : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= skip_page(FIRST);
    else if (load) addr <= skip_page(FIRST);
    else if (step) addr <= skip_page(addr + 6'd1);
  end

  AST_NO_PAGE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) |-> addr[2:0] != 3'd0); // R7

endmodule

// File: rtl/spi_tx_select.sv
module spi_tx_select
  import spi_eng_pkg::*;
#(
  parameter int         IDX_W          = 8,
  parameter logic [5:0] FIFO_DATA_REG  = 6'h02,
  parameter logic [5:0] FIFO_LEVEL_REG = 6'h04
) (
  input  logic [2:0]       op,
  input  logic             phase,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [5:0]       reg_no,
  input  logic [7:0]       wdata,
  input  logic [5:0]       set_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       tx_byte,
  output logic             need_wr
);
  logic first;
  assign first = (idx == '0);

  always_comb begin
    tx_byte = 8'h00;
    need_wr = 1'b0;
    unique case (op)
      OP_REG_WR:  tx_byte = first ? addr_byte(reg_no, 1'b0) : wdata;
      OP_REG_RD:  tx_byte = first ? addr_byte(reg_no, 1'b1) : 8'h00;
      OP_FIFO_WR: begin
        need_wr = !first;
        tx_byte = first ? addr_byte(FIFO_DATA_REG, 1'b0) : wr_data;
      end
      OP_FIFO_RD: begin
        if (!phase)              tx_byte = first ? addr_byte(FIFO_LEVEL_REG, 1'b1) : 8'h00;
        else if (first)          tx_byte = addr_byte(FIFO_DATA_REG, 1'b1);
        else if (idx == last_idx) tx_byte = 8'h00;
        else                     tx_byte = addr_byte(FIFO_DATA_REG, 1'b0);
      end
      OP_REG_SET: begin
        need_wr = idx[0];
        tx_byte = idx[0] ? wr_data : addr_byte(set_addr, 1'b0);
      end
      default: tx_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_eng_pkg::*;
#(
  parameter int         HALF_DIV       = 4,
  parameter int         LEN_W          = 7,
  parameter int         FIFO_MAX       = 64,
  parameter logic [5:0] FIFO_DATA_REG  = 6'h02,
  parameter logic [5:0] FIFO_LEVEL_REG = 6'h04,
  parameter logic [5:0] SET_FIRST      = 6'h10,
  parameter logic [5:0] SET_LAST       = 6'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [5:0]       req_addr,
  input  logic [7:0]       req_wdata,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  input  logic             spi_miso
);
  localparam int IDX_W   = LEN_W + 1;
  localparam int SET_CNT = set_count(int'(SET_FIRST), int'(SET_LAST));
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  eng_state_e       state;
  logic [2:0]       op_q;
  logic [5:0]       addr_q;
  logic [7:0]       wdata_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx, last_idx, rd_n_q;
  logic             phase, more_q;
  logic [GAP_W-1:0] gap_cnt;
  logic             rd_valid_q, done_q;
  logic [7:0]       rd_data_q;

  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_rx, tx_byte;
  logic       need_wr, go;
  logic [5:0] set_addr;
  logic [IDX_W-1:0] fw_last, lvl_n;
  logic       last_byte;

  assign req_ready = (state == ST_IDLE);
  assign spi_cs_n  = (state == ST_IDLE) || (state == ST_GAP);
  assign go        = (state == ST_LOAD) && (!need_wr || wr_valid);
  assign wr_ready  = (state == ST_LOAD) && need_wr;
  assign sh_start  = go;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign done      = done_q;
  assign last_byte = (idx == last_idx);

  always_comb begin
    fw_last = (int'(req_len) > FIFO_MAX) ? IDX_W'(FIFO_MAX) : IDX_W'(req_len);
    lvl_n   = (int'(sh_rx) > int'(len_q)) ? IDX_W'(len_q) : IDX_W'(sh_rx);
  end

  spi_bit_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(tx_byte),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx)
  );

  spi_regset_walk #(.FIRST(SET_FIRST)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load((state == ST_IDLE) && req_valid),
    .step((state == ST_SHIFT) && sh_done && (op_q == OP_REG_SET) && idx[0]),
    .addr(set_addr)
  );

  spi_tx_select #(
    .IDX_W(IDX_W), .FIFO_DATA_REG(FIFO_DATA_REG), .FIFO_LEVEL_REG(FIFO_LEVEL_REG)
  ) u_sel (
    .op(op_q), .phase(phase), .idx(idx), .last_idx(last_idx),
    .reg_no(addr_q), .wdata(wdata_q), .set_addr(set_addr), .wr_data(wr_data),
    .tx_byte(tx_byte), .need_wr(need_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      len_q      <= '0;
      idx        <= '0;
      last_idx   <= '0;
      rd_n_q     <= '0;
      phase      <= 1'b0;
      more_q     <= 1'b0;
      gap_cnt    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          len_q   <= req_len;
          idx     <= '0;
          phase   <= 1'b0;
          more_q  <= 1'b0;
          if (!op_known(req_op)) begin
            done_q <= 1'b1;
          end else begin
            state <= ST_LOAD;
            unique case (req_op)
              OP_FIFO_WR: last_idx <= fw_last;
              OP_REG_SET: last_idx <= IDX_W'(2 * SET_CNT - 1);
              default:    last_idx <= IDX_W'(1);
            endcase
          end
        end
        ST_LOAD: if (go) state <= ST_SHIFT;
        ST_SHIFT: if (sh_done) begin
          if ((op_q == OP_REG_RD && idx == IDX_W'(1)) ||
              (op_q == OP_FIFO_RD && phase && idx != '0)) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= sh_rx;
          end
          if (op_q == OP_FIFO_RD && !phase && idx == IDX_W'(1)) rd_n_q <= lvl_n;
          if (last_byte) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
            if (op_q == OP_FIFO_RD && !phase && lvl_n != '0) more_q <= 1'b1;
            else                                            done_q <= 1'b1;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= ST_LOAD;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            if (more_q) begin
              more_q   <= 1'b0;
              phase    <= 1'b1;
              idx      <= '0;
              last_idx <= rd_n_q;
              state    <= ST_LOAD;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycles chip select has been high, saturating; used only by the checks below
  logic [GAP_W-1:0] cs_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cs_hi_cnt <= GAP_W'(GAP_CYC);
    else if (!spi_cs_n)                          cs_hi_cnt <= '0;
    else if (cs_hi_cnt != GAP_W'(GAP_CYC))       cs_hi_cnt <= cs_hi_cnt + GAP_W'(1);
  end

  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> cs_hi_cnt == GAP_W'(GAP_CYC)); // R9
  AST_CS_LOW_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !spi_cs_n); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R8
  AST_WR_READY_BETWEEN_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !sh_busy)); // R12
  AST_NO_TAKE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !req_ready); // R10
  AST_READ_DONE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_REG_RD) |-> rd_valid); // R3

endmodule

// File: tb/sim_spi_reg_engine.sv
`timescale 1ns/1ps
module sim_spi_reg_engine;
  localparam int HD = 2;
  localparam int BYTE_CYC = 16 * HD + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [6:0] req_len = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, done;
  logic [7:0] rd_data;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_reg_engine #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  byte unsigned mosi_q[$];
  byte unsigned miso_q[$];
  byte unsigned rd_q[$];
  byte unsigned wr_q[$];
  int flen_q[$];
  int frames = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- SPI slave model (scoreboard side for MOSI) ----------------
  byte unsigned s_rx, s_tx;
  int s_bits = 0, s_nb = 0, s_flen = 0;
  bit s_open = 1'b0;

  function automatic byte unsigned pop_miso();
    if (miso_q.size() == 0) return 8'h00;
    return miso_q.pop_front();
  endfunction

  always @(negedge spi_cs_n) begin
    frames++;
    s_open = 1'b1;
    s_nb = 0;
    s_bits = 0;
    if (flen_q.size() == 0) begin
      s_flen = 0;
      chk(1'b0, "R10", "unexpected frame", frames, 0);
    end else s_flen = flen_q.pop_front();
    s_tx = pop_miso();
    spi_miso = s_tx[7];
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    s_rx = {s_rx[6:0], spi_mosi};
    s_bits++;
    if (s_bits == 8) begin
      s_bits = 0;
      s_nb++;
      if (mosi_q.size() == 0) chk(1'b0, "R1", "extra MOSI byte", s_rx, 0);
      else begin
        byte unsigned e;
        e = mosi_q.pop_front();
        chk(s_rx == e, "R1", "MOSI byte", s_rx, e);
      end
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (s_bits == 0) begin
      if (s_nb < s_flen) begin
        s_tx = pop_miso();
        spi_miso = s_tx[7];
      end
    end else begin
      s_tx = {s_tx[6:0], 1'b0};
      spi_miso = s_tx[7];
    end
  end

  always @(posedge spi_cs_n) if (s_open) begin
    s_open = 1'b0;
    chk(s_nb == s_flen && s_bits == 0, "R8", "frame length in bytes", s_nb, s_flen);
  end

  // ---------------- read-stream monitor ----------------
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (rd_q.size() == 0) chk(1'b0, "R6", "unexpected rd_valid", rd_data, 0);
    else begin
      byte unsigned e;
      e = rd_q.pop_front();
      chk(rd_data == e, "R5", "read byte", rd_data, e);
    end
  end

  // ---------------- protocol watchers ----------------
  int gap_viol = 0, rdy_viol = 0, mosi_viol = 0, hi_cnt = 1000;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!spi_cs_n && p_cs && hi_cnt < 2 * HD) gap_viol++;
    hi_cnt = spi_cs_n ? hi_cnt + 1 : 0;
    if (!spi_cs_n && req_ready) rdy_viol++;
    if (spi_sclk && p_sclk && spi_mosi != p_mosi) mosi_viol++;
    if (spi_cs_n && spi_sclk) mosi_viol++;
    p_cs = spi_cs_n; p_sclk = spi_sclk; p_mosi = spi_mosi;
  end

  // ---------------- write-stream source ----------------
  bit stall_en = 1'b0;
  int stall_ctr = 0;
  bit wr_took = 1'b0;
  always @(posedge clk) if (wr_valid && wr_ready) wr_took = 1'b1;
  always @(negedge clk) begin
    if (wr_took) begin
      wr_took = 1'b0;
      if (wr_q.size() != 0) void'(wr_q.pop_front());
    end
    stall_ctr++;
    wr_valid = (wr_q.size() != 0) && !(stall_en && (stall_ctr % 3 == 1));
    wr_data = (wr_q.size() != 0) ? wr_q[0] : 8'h00;
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [7:0] d,
                       input logic [6:0] n, output int k);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_len = n; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!done) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(mosi_q.size() == 0, req, "MOSI bytes left", mosi_q.size(), 0);
    chk(rd_q.size() == 0, req, "read bytes left", rd_q.size(), 0);
    chk(flen_q.size() == 0, req, "frames not seen", flen_q.size(), 0);
  endtask

  task automatic fifo_read(input int level, input int maxn, input byte unsigned base);
    int n, k;
    n = (level < maxn) ? level : maxn;
    flen_q.push_back(2);
    mosi_q.push_back(8'h88); mosi_q.push_back(8'h00);
    miso_q.push_back(8'h00); miso_q.push_back(byte'(level));
    if (n > 0) begin
      flen_q.push_back(n + 1);
      miso_q.push_back(8'h00);
      for (int i = 0; i <= n; i++) begin
        mosi_q.push_back(i == 0 ? 8'h84 : (i == n ? 8'h00 : 8'h04));
        if (i > 0) begin
          miso_q.push_back(byte'(base + i));
          rd_q.push_back(byte'(base + i));
        end
      end
    end
    issue(3'd3, 6'h00, 8'h00, 7'(maxn), k);
    drained("R5");
  endtask

  initial begin
    int k, f0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R8", "reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R8", "reset sclk", spi_sclk, 0);
    chk(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
    chk(rd_valid == 1'b0 && done == 1'b0, "R3", "reset rd_valid/done", {rd_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R11: register write
    flen_q.push_back(2);
    mosi_q.push_back(8'h2A); mosi_q.push_back(8'h3C);
    miso_q.push_back(8'h11); miso_q.push_back(8'h22);
    issue(3'd0, 6'h15, 8'h3C, 7'd0, k);
    chk(k == 2 * BYTE_CYC + 1, "R11", "reg write done latency", k, 2 * BYTE_CYC + 1);
    drained("R2");

    // R3 / R11: register read of 0x3F
    flen_q.push_back(2);
    mosi_q.push_back(8'hFE); mosi_q.push_back(8'h00);
    miso_q.push_back(8'h00); miso_q.push_back(8'h9B);
    rd_q.push_back(8'h9B);
    issue(3'd1, 6'h3F, 8'hFF, 7'd0, k);
    chk(k == 2 * BYTE_CYC + 1, "R11", "reg read done latency", k, 2 * BYTE_CYC + 1);
    drained("R3");

    // R3: register read of 0x00
    flen_q.push_back(2);
    mosi_q.push_back(8'h80); mosi_q.push_back(8'h00);
    miso_q.push_back(8'hFF); miso_q.push_back(8'h5A);
    rd_q.push_back(8'h5A);
    issue(3'd1, 6'h00, 8'h00, 7'd0, k);
    drained("R3");

    // R4 / R12: FIFO write of 5 with stalls on the write stream
    stall_en = 1'b1;
    flen_q.push_back(6);
    mosi_q.push_back(8'h04);
    for (int i = 0; i < 5; i++) begin
      wr_q.push_back(byte'(8'hC0 + i));
      mosi_q.push_back(byte'(8'hC0 + i));
    end
    issue(3'd2, 6'h00, 8'h00, 7'd5, k);
    chk(k > 6 * BYTE_CYC + 1, "R12", "stalled frame longer than unstalled", k, 6 * BYTE_CYC + 1);
    drained("R12");
    stall_en = 1'b0;

    // R4: length 70 clamps to 64, two payload bytes stay untaken
    flen_q.push_back(65);
    mosi_q.push_back(8'h04);
    for (int i = 0; i < 66; i++) begin
      wr_q.push_back(byte'(i * 3 + 1));
      if (i < 64) mosi_q.push_back(byte'(i * 3 + 1));
    end
    issue(3'd2, 6'h00, 8'h00, 7'd70, k);
    chk(wr_q.size() == 2, "R4", "payload bytes left untaken", wr_q.size(), 2);
    drained("R4");
    wr_q.delete();
    repeat (2) @(negedge clk);

    // R4: length 0, address only
    flen_q.push_back(1);
    mosi_q.push_back(8'h04);
    issue(3'd2, 6'h00, 8'h00, 7'd0, k);
    drained("R4");

    // R5: FIFO reads, level limited and request limited
    fifo_read(6, 4, 8'h40);
    fifo_read(3, 10, 8'h70);
    fifo_read(1, 1, 8'hE0);

    // R6: empty FIFO, single frame only
    f0 = frames;
    fifo_read(0, 8, 8'h00);
    repeat (60) @(negedge clk);
    chk(frames == f0 + 1, "R6", "frames for empty FIFO read", frames - f0, 1);

    // R7: register-set write
    flen_q.push_back(84);
    for (int a = 16; a < 64; a++) begin
      if (a % 8 != 0) begin
        mosi_q.push_back(byte'(a << 1));
        mosi_q.push_back(byte'(a ^ 8'h5A));
        wr_q.push_back(byte'(a ^ 8'h5A));
      end
    end
    issue(3'd4, 6'h00, 8'h00, 7'd0, k);
    chk(k == 84 * BYTE_CYC + 1, "R7", "register-set frame time", k, 84 * BYTE_CYC + 1);
    chk(wr_q.size() == 0, "R7", "payload bytes left", wr_q.size(), 0);
    drained("R7");

    // R13: unknown opcode
    f0 = frames;
    issue(3'd6, 6'h01, 8'h01, 7'd1, k);
    chk(k == 1, "R13", "done after unknown opcode", k, 1);
    repeat (40) @(negedge clk);
    chk(frames == f0, "R13", "frames for unknown opcode", frames - f0, 0);

    chk(gap_viol == 0, "R9", "short chip-select gaps", gap_viol, 0);
    chk(rdy_viol == 0, "R10", "req_ready inside frame", rdy_viol, 0);
    chk(mosi_viol == 0, "R8", "MOSI/SCLK rule breaks", mosi_viol, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule